// File: doc/BRIEF.md
# Linked Channel Vector Memory Mapper

This block holds the per-channel vector storage of a pattern memory and maps each access onto a physical bank and row. Channels come in segments of sixteen. A link mode can pool the storage of neighbouring channels. In by-2 mode, each even channel owns its own bank and the next bank up, so its logical depth doubles. The odd channels are then locked out. In by-4 mode, a channel whose index is a multiple of four owns four consecutive banks, and the other three channels of its group may not be used. Because the groups are aligned, a linked group never crosses a segment boundary.

A requester presents a link mode, a channel, a logical vector address, a write flag and write data, and raises a request for one cycle while the block is idle. A four-state machine (IDLE, MAP, EXEC, FAULT) takes the request, resolves the physical location, and then either performs the access or rejects it. It reports the physical bank and row it used. A rejected access sets a sticky error flag and leaves storage untouched. The link mode register only takes a new mode while the machine is in IDLE, and taking a new mode clears the error flag.

State transitions: IDLE goes to MAP on `req_i`. MAP goes to EXEC when the mapping is legal and to FAULT when it is not. EXEC and FAULT both return to IDLE after one cycle.

Top module: `lnk_vecmem_mapper`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `phys_bank_o`, `phys_row_o` and `rdata_o` are all zero, the active mode is none (code 0), and every stored word reads as zero.
- R2: Mode code 0 (no link) accepts every channel for addresses 0 to DEPTH-1. The bank is the channel and the row is the address.
- R3: Mode code 1 (by-2) accepts only even channels, for addresses 0 to 2*DEPTH-1. The bank is the channel plus address bit ROW_W, and the row is the low ROW_W address bits.
- R4: Mode code 2 (by-4) accepts only channels that are multiples of 4, for addresses 0 to 4*DEPTH-1. The bank is the channel plus the two address bits above the row, and the row is the low ROW_W address bits.
- R5: An access to a channel that the active mode forbids ends in FAULT. It sets `err_o`, pulses `done_o`, reports bank 0 and row 0, and changes no stored word.
- R6: An address at or beyond the linked depth of the active mode is treated the same way as R5.
- R7: Mode code 3 is reserved, and every access in that mode ends in FAULT.
- R8: The mode on `link_mode_i` is adopted on each clock edge taken in IDLE. A request raised in the same cycle is mapped with that new mode. While the machine is busy, changes on `link_mode_i` have no effect. Adopting a mode that differs from the active one clears `err_o`.
- R9: A request accepted at clock edge E0 is mapped at E1 and completed at E2. `busy_o` is high from E0 to E2. `done_o` is high for exactly the one cycle after E2. Requests raised while busy are ignored.
- R10: A read returns on `rdata_o`, together with `done_o`, the word last written to the same physical bank and row, whichever mode wrote it.
- R11: `err_o` stays set across later successful accesses until a mode change clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_mode_i | input | 2 | Link mode: 0 none, 1 by-2, 2 by-4, 3 reserved |
| req_i | input | 1 | Access request, taken only in IDLE |
| we_i | input | 1 | 1 = write, 0 = read |
| ch_i | input | CH_W (5) | Logical channel |
| addr_i | input | ROW_W+2 (6) | Logical vector address |
| wdata_i | input | DATA_W (8) | Write data |
| busy_o | output | 1 | Machine is not in IDLE |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky rejected-access flag |
| phys_bank_o | output | CH_W (5) | Physical bank used by the last access |
| phys_row_o | output | ROW_W (4) | Physical row used by the last access |
| rdata_o | output | DATA_W (8) | Read data |

## Verification
A mode change and a new request can arrive on the same IDLE edge. In that case, the mode adoption (which also clears the error) and the capture of the request happen together. The bench raises a request for an odd channel while switching the mode from reserved to no-link in that same cycle. It expects a legal access with `err_o` cleared, which shows that the request saw the new mode. It also checks the opposite case: a mode change raised while the machine is busy must leave `err_o` set until the first IDLE edge after `done_o`.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    typedef enum logic [1:0] {
        LNK_NONE = 2'd0,
        LNK_BY2  = 2'd1,
        LNK_BY4  = 2'd2,
        LNK_RSVD = 2'd3
    } lnk_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MAP   = 2'd1,
        ST_EXEC  = 2'd2,
        ST_FAULT = 2'd3
    } lnk_state_e;

endpackage

// File: rtl/lnk_addr_map.sv
module lnk_addr_map
    import lnk_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int DEPTH  = 16,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ROW_W  = $clog2(DEPTH),
    localparam int ADDR_W = ROW_W + 2
) (
    input  lnk_mode_e         mode,
    input  logic [CH_W-1:0]   ch,
    input  logic [ADDR_W-1:0] addr,
    output logic              ok,
    output logic [CH_W-1:0]   bank,
    output logic [ROW_W-1:0]  row
);
    logic [1:0] sib;

    assign sib = addr[ADDR_W-1:ROW_W];

    always_comb begin
        ok   = 1'b0;
        bank = '0;
        row  = '0;
        unique case (mode)
            LNK_NONE: ok = (sib == 2'd0);
            LNK_BY2:  ok = !ch[0] && !sib[1];
            LNK_BY4:  ok = (ch[1:0] == 2'd0);
            LNK_RSVD: ok = 1'b0;
        endcase
        if (ok) begin
            bank = ch | CH_W'(sib);
            row  = addr[ROW_W-1:0];
        end
    end

endmodule

// File: rtl/lnk_bank_array.sv
module lnk_bank_array #(
    parameter int NUM_CH = 32,
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int ROW_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CH_W-1:0]   bank,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] bank_rd [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int r = 0; r < DEPTH; r++) mem[r] <= '0;
            end else if (we && (bank == CH_W'(g))) begin
                mem[row] <= wdata;
            end
        end

        assign bank_rd[g] = mem[row];
    end

    assign rdata = bank_rd[bank];

endmodule

// File: rtl/lnk_vecmem_mapper.sv
module lnk_vecmem_mapper
    import lnk_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ROW_W  = $clog2(DEPTH),
    localparam int ADDR_W = ROW_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        link_mode_i,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [CH_W-1:0]   ch_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [CH_W-1:0]   phys_bank_o,
    output logic [ROW_W-1:0]  phys_row_o,
    output logic [DATA_W-1:0] rdata_o
);
    lnk_state_e        state, state_nx;
    lnk_mode_e         mode_q;
    logic              we_q;
    logic [CH_W-1:0]   ch_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              map_ok;
    logic [CH_W-1:0]   map_bank;
    logic [ROW_W-1:0]  map_row;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rdata;

    lnk_addr_map #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_map (
        .mode (mode_q),
        .ch   (ch_q),
        .addr (addr_q),
        .ok   (map_ok),
        .bank (map_bank),
        .row  (map_row)
    );

    assign mem_we = (state == ST_EXEC) && we_q;

    lnk_bank_array #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_banks (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .bank  (phys_bank_o),
        .row   (phys_row_o),
        .wdata (wdata_q),
        .rdata (mem_rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_i) state_nx = ST_MAP;
            ST_MAP:   state_nx = map_ok ? ST_EXEC : ST_FAULT;
            ST_EXEC:  state_nx = ST_IDLE;
            ST_FAULT: state_nx = ST_IDLE;
        endcase
    end

    assign busy_o = (state != ST_IDLE);

    // outputs and request registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= LNK_NONE;
            we_q        <= 1'b0;
            ch_q        <= '0;
            addr_q      <= '0;
            wdata_q     <= '0;
            phys_bank_o <= '0;
            phys_row_o  <= '0;
            rdata_o     <= '0;
            err_o       <= 1'b0;
            done_o      <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    mode_q <= lnk_mode_e'(link_mode_i);
                    if (lnk_mode_e'(link_mode_i) != mode_q) err_o <= 1'b0;
                    if (req_i) begin
                        we_q    <= we_i;
                        ch_q    <= ch_i;
                        addr_q  <= addr_i;
                        wdata_q <= wdata_i;
                    end
                end
                ST_MAP: begin
                    phys_bank_o <= map_bank;
                    phys_row_o  <= map_row;
                end
                ST_EXEC: begin
                    if (!we_q) rdata_o <= mem_rdata;
                    done_o <= 1'b1;
                end
                ST_FAULT: begin
                    err_o  <= 1'b1;
                    done_o <= 1'b1;
                end
            endcase
        end
    end

    assert_map_exits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MAP) |=> (state == ST_EXEC || state == ST_FAULT));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_fault_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT) |=> (err_o && done_o && !busy_o));

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(mode_q));

    assert_native_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && mode_q == LNK_NONE) |-> (phys_bank_o == ch_q));

    assert_pair_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && mode_q == LNK_BY2)
            |-> (phys_bank_o[CH_W-1:1] == ch_q[CH_W-1:1]));

    assert_quad_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && mode_q == LNK_BY4)
            |-> (phys_bank_o[CH_W-1:2] == ch_q[CH_W-1:2]));

    assert_no_rsvd_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC) |-> (mode_q != LNK_RSVD));

endmodule

// File: tb/sim_lnk_vecmem_mapper.sv
module sim_lnk_vecmem_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS = 20;

    // {mode[39:38], we[37], ch[36:32], addr[31:26], wdata[25:18], fault[17],
    //  bank[16:12], row[11:8], rdata[7:0]}
    localparam logic [39:0] TBL [NROWS] = '{
        {2'd0,1'b1,5'd3, 6'd5, 8'hA5,1'b0,5'd3, 4'd5, 8'h00},
        {2'd0,1'b0,5'd3, 6'd5, 8'h00,1'b0,5'd3, 4'd5, 8'hA5},
        {2'd0,1'b1,5'd31,6'd15,8'h3C,1'b0,5'd31,4'd15,8'h00},
        {2'd0,1'b0,5'd31,6'd15,8'h00,1'b0,5'd31,4'd15,8'h3C},
        {2'd0,1'b1,5'd2, 6'd16,8'hFF,1'b1,5'd0, 4'd0, 8'h00},
        {2'd0,1'b0,5'd3, 6'd5, 8'h00,1'b0,5'd3, 4'd5, 8'hA5},
        {2'd1,1'b1,5'd4, 6'd21,8'h5A,1'b0,5'd5, 4'd5, 8'h00},
        {2'd1,1'b0,5'd4, 6'd21,8'h00,1'b0,5'd5, 4'd5, 8'h5A},
        {2'd1,1'b1,5'd5, 6'd0, 8'hEE,1'b1,5'd0, 4'd0, 8'h00},
        {2'd1,1'b0,5'd4, 6'd5, 8'h00,1'b0,5'd4, 4'd5, 8'h00},
        {2'd1,1'b1,5'd16,6'd31,8'h77,1'b0,5'd17,4'd15,8'h00},
        {2'd1,1'b0,5'd16,6'd31,8'h00,1'b0,5'd17,4'd15,8'h77},
        {2'd1,1'b0,5'd2, 6'd32,8'h00,1'b1,5'd0, 4'd0, 8'h00},
        {2'd2,1'b1,5'd12,6'd63,8'hE1,1'b0,5'd15,4'd15,8'h00},
        {2'd2,1'b0,5'd12,6'd63,8'h00,1'b0,5'd15,4'd15,8'hE1},
        {2'd2,1'b1,5'd14,6'd0, 8'hDD,1'b1,5'd0, 4'd0, 8'h00},
        {2'd2,1'b0,5'd28,6'd37,8'h00,1'b0,5'd30,4'd5, 8'h00},
        {2'd0,1'b0,5'd15,6'd15,8'h00,1'b0,5'd15,4'd15,8'hE1},
        {2'd0,1'b0,5'd5, 6'd5, 8'h00,1'b0,5'd5, 4'd5, 8'h5A},
        {2'd3,1'b0,5'd0, 6'd0, 8'h00,1'b1,5'd0, 4'd0, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] link_mode_i = 2'd0;
    logic       req_i = 1'b0;
    logic       we_i = 1'b0;
    logic [4:0] ch_i = '0;
    logic [5:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic       busy_o, done_o, err_o;
    logic [4:0] phys_bank_o;
    logic [3:0] phys_row_o;
    logic [7:0] rdata_o;

    int n_run = 0;
    int n_fail = 0;
    logic busy_seen, done_early;

    always #(CLK_PERIOD/2) clk = ~clk;

    lnk_vecmem_mapper u0 (
        .clk(clk), .rst_n(rst_n), .link_mode_i(link_mode_i), .req_i(req_i),
        .we_i(we_i), .ch_i(ch_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .phys_bank_o(phys_bank_o), .phys_row_o(phys_row_o), .rdata_o(rdata_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One access; returns at the negedge after completion (done_o high).
    task automatic run(input logic [1:0] md, input logic wr, input logic [4:0] ch,
                       input logic [5:0] ad, input logic [7:0] wd,
                       input int mid_mode, input bit busy_req);
        @(negedge clk);
        link_mode_i = md; req_i = 1'b1; we_i = wr; ch_i = ch; addr_i = ad; wdata_i = wd;
        @(negedge clk);
        busy_seen  = busy_o;
        done_early = done_o;
        req_i = busy_req;
        if (busy_req) begin
            we_i = 1'b1; ch_i = 5'd1; addr_i = 6'd1; wdata_i = 8'h99;
        end
        if (mid_mode >= 0) link_mode_i = 2'(mid_mode);
        @(negedge clk);
        req_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic err_m;
        logic [1:0] mode_m;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 done", 32'(done_o), 0);
        chk("R1 err", 32'(err_o), 0);
        chk("R1 bank/row", {phys_bank_o, phys_row_o}, 0);
        chk("R1 rdata", 32'(rdata_o), 0);
        rst_n = 1'b1;

        err_m = 1'b0;
        mode_m = 2'd0;
        for (int i = 0; i < NROWS; i++) begin
            logic [39:0] v;
            string tg;
            v = TBL[i];
            run(v[39:38], v[37], v[36:32], v[31:26], v[25:18], -1, 1'b0);
            if (v[39:38] != mode_m) err_m = 1'b0;
            mode_m = v[39:38];
            if (v[17]) err_m = 1'b1;
            case (v[39:38])
                2'd0:    tg = "R2";
                2'd1:    tg = "R3";
                2'd2:    tg = "R4";
                default: tg = "R7";
            endcase
            if (v[17] && v[39:38] != 2'd3) tg = {tg, " R5/R6 reject"};
            chk($sformatf("%s row%0d bank", tg, i), 32'(phys_bank_o), 32'(v[16:12]));
            chk($sformatf("%s row%0d row", tg, i), 32'(phys_row_o), 32'(v[11:8]));
            chk($sformatf("R9 row%0d done", i), 32'(done_o), 1);
            chk($sformatf("R11 row%0d err", i), 32'(err_o), 32'(err_m));
            if (!v[37] && !v[17])
                chk($sformatf("R10 row%0d rdata", i), 32'(rdata_o), 32'(v[7:0]));
        end

        // R8: mode change together with a request (mode is 3, err set)
        run(2'd0, 1'b0, 5'd1, 6'd1, 8'h00, -1, 1'b0);
        chk("R8 same-cycle err cleared", 32'(err_o), 0);
        chk("R8 same-cycle bank", 32'(phys_bank_o), 1);
        chk("R8 same-cycle rdata", 32'(rdata_o), 0);

        // R5: rejected write leaves storage untouched
        run(2'd1, 1'b1, 5'd1, 6'd0, 8'h42, -1, 1'b0);
        chk("R5 odd channel err", 32'(err_o), 1);
        run(2'd1, 1'b0, 5'd0, 6'd1, 8'h00, -1, 1'b0);
        chk("R11 err sticky", 32'(err_o), 1);
        // R8: mode change while busy must not act before IDLE
        run(2'd1, 1'b0, 5'd0, 6'd0, 8'h00, 0, 1'b0);
        chk("R8 busy mode change ignored", 32'(err_o), 1);
        @(negedge clk);
        chk("R8 idle mode adopted clears err", 32'(err_o), 0);
        chk("R9 done one cycle", 32'(done_o), 0);
        run(2'd0, 1'b0, 5'd1, 6'd0, 8'h00, -1, 1'b0);
        chk("R5 bank1 row0 untouched", 32'(rdata_o), 0);

        // R9: timing and request while busy
        run(2'd0, 1'b1, 5'd0, 6'd0, 8'h11, -1, 1'b1);
        chk("R9 busy after accept", 32'(busy_seen), 1);
        chk("R9 no early done", 32'(done_early), 0);
        chk("R9 idle at done", 32'(busy_o), 0);
        run(2'd0, 1'b0, 5'd1, 6'd1, 8'h00, -1, 1'b0);
        chk("R9 busy request ignored", 32'(rdata_o), 0);
        run(2'd0, 1'b0, 5'd0, 6'd0, 8'h00, -1, 1'b0);
        chk("R10 readback", 32'(rdata_o), 32'h11);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule